// File: doc/BRIEF.md
# Basic Interval Timer with Start-Up Wait

This block is a free-running interval timer for a small controller. A prescaler counts system clock cycles, and the interval counter advances once every 2^tap cycles. The tap is one of four taps chosen through a small mode register. Each time the counter wraps, the block raises a one-cycle interrupt request and toggles a square-wave clock output.

The same counter also decides when the processor may start. After reset the block sits in `ST_RSTWAIT`. In that state it counts at a fixed, longer reset tap and keeps `wait_done_o` low until the first wrap. It then enters `ST_RUN`. A stop request in `ST_RUN` moves it to `ST_STOP`, where the prescaler and counter are frozen. A wake event clears the prescaler and counter and moves it to `ST_WAKEWAIT`. That state holds the processor back until the first wrap at the programmed interval, then returns to `ST_RUN`.

The four transitions are:
- RSTWAIT→RUN on overflow
- RUN→STOP on stop request
- STOP→WAKEWAIT on wake
- WAKEWAIT→RUN on overflow

Top module: `basic_itimer`

## Requirements
- R1: While reset is held, `wait_done_o`, `irq_o` and `clk_out_o` are 0 and `count_o` is 0.
- R2: After reset release, `wait_done_o` rises exactly 2^(TAP_RST+CNT_W) clock edges later, and no interrupt is raised during that wait.
- R3: The mode write field `mode_wdata[1:0]` selects the interval: code k gives an interrupt every 2^(TAPk+CNT_W) cycles, where TAP0 is the slowest tap and TAP3 the fastest.
- R4: Each interrupt request is a single-cycle pulse on `irq_o`.
- R5: `clk_out_o` changes level on exactly the edge that raises `irq_o`, giving a 50% square wave with period twice the interval.
- R6: A mode write with `mode_wdata[2]` = 1 zeroes the counter and prescaler, so `count_o` reads 0 and the next interrupt comes exactly one full interval after the write edge.
- R7: `count_o` advances by one every 2^tap cycles at the selected tap.
- R8: A stop request in run freezes `count_o` and `clk_out_o`, drops `wait_done_o`, and raises no interrupt while stopped.
- R9: A wake event clears the counter and holds `wait_done_o` low for one full selected interval. The overflow that ends this wait raises no interrupt, and the next interrupt follows one interval later.
- R10: `stop_req` has no effect outside run, and `wake` has no effect outside stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock fx |
| rst_n | input | 1 | active-low asynchronous reset |
| mode_we | input | 1 | mode register write strobe |
| mode_wdata | input | 3 | [1:0] interval select, [2] clear counter and prescaler |
| stop_req | input | 1 | processor entering stop mode |
| wake | input | 1 | stop-mode release event |
| irq_o | output | 1 | interval interrupt request pulse |
| clk_out_o | output | 1 | square-wave clock output |
| wait_done_o | output | 1 | high when the processor may run |
| count_o | output | CNT_W | current interval counter value |

## Verification
The bench runs a reduced configuration, a 4-bit counter with small taps, and sweeps all four interval codes. For each code it measures the first interval after a clear and a following full period, computed arithmetically.

A prescaler cleared off by one, or a tap decoded from the wrong bit, shows up as a period that is off by one or by a power of two. An interrupt leaking out of either wait state shows up as an extra pulse before `wait_done_o` rises. A frozen counter that still creeps during stop shows up as a changed `count_o`. Stray `stop_req` during the reset wait and stray `wake` during run must leave the measured timing unchanged, which catches a design that decodes those inputs in every state.

// File: rtl/bit_pkg.sv
package bit_pkg;

    typedef enum logic [1:0] {
        ST_RSTWAIT  = 2'd0,
        ST_RUN      = 2'd1,
        ST_STOP     = 2'd2,
        ST_WAKEWAIT = 2'd3
    } bt_state_e;

    typedef struct packed {
        logic       clr;
        logic [1:0] sel;
    } bt_mode_t;

    localparam int NUM_TAPS = 5;
    localparam int RST_IDX  = 4;

endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
    parameter int TAP0    = 13,
    parameter int TAP1    = 10,
    parameter int TAP2    = 8,
    parameter int TAP3    = 6,
    parameter int TAP_RST = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [2:0] idx,
    output logic       tick
);
    localparam int TAPV [bit_pkg::NUM_TAPS] = '{TAP0, TAP1, TAP2, TAP3, TAP_RST};

    function automatic int max_tap();
        int m = 1;
        for (int i = 0; i < bit_pkg::NUM_TAPS; i++) if (TAPV[i] > m) m = TAPV[i];
        return m;
    endfunction

    localparam int PRE_W = max_tap();

    logic [PRE_W-1:0] pre;
    logic [7:0]       tick_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pre <= '0;
        else if (clr)   pre <= '0;
        else if (run)   pre <= pre + 1'b1;
    end

    for (genvar g = 0; g < bit_pkg::NUM_TAPS; g++) begin : g_tap
        localparam int TW = TAPV[g];
        assign tick_v[g] = &pre[TW-1:0];
    end
    assign tick_v[7:bit_pkg::NUM_TAPS] = '0;

    assign tick = run && !clr && tick_v[idx];

    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre == '0)); // R6

endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (en)   cnt <= cnt + 1'b1;
    end

    assign ovf = en && (&cnt);

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt)); // R8

endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ovf,
    input  logic                stop_req,
    input  logic                wake,
    output bit_pkg::bt_state_e  state_o,
    output logic                run,
    output logic                use_rst_tap,
    output logic                clr_wake,
    output logic                in_run
);
    import bit_pkg::*;

    bt_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RSTWAIT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RSTWAIT:  if (ovf)      nxt = ST_RUN;
            ST_RUN:      if (stop_req) nxt = ST_STOP;
            ST_STOP:     if (wake)     nxt = ST_WAKEWAIT;
            ST_WAKEWAIT: if (ovf)      nxt = ST_RUN;
            default:                   nxt = ST_RSTWAIT;
        endcase
    end

    always_comb begin
        run         = (state != ST_STOP);
        use_rst_tap = (state == ST_RSTWAIT);
        clr_wake    = (state == ST_STOP) && wake;
        in_run      = (state == ST_RUN);
    end

    assign state_o = state;

    AST_WAIT_ENDS_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_run) |-> $past(ovf)); // R2

endmodule

// File: rtl/basic_itimer.sv
module basic_itimer #(
    parameter int CNT_W   = 8,
    parameter int TAP0    = 13,
    parameter int TAP1    = 10,
    parameter int TAP2    = 8,
    parameter int TAP3    = 6,
    parameter int TAP_RST = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [2:0]       mode_wdata,
    input  logic             stop_req,
    input  logic             wake,
    output logic             irq_o,
    output logic             clk_out_o,
    output logic             wait_done_o,
    output logic [CNT_W-1:0] count_o
);
    import bit_pkg::*;

    bt_mode_t   wr;
    logic [1:0] sel_q;
    logic       clr, tick, ovf, run, use_rst, clr_wake, in_run;
    logic [2:0] idx;
    logic       irq_q, clk_q;
    bt_state_e  st;

    assign wr  = bt_mode_t'(mode_wdata);
    assign clr = (mode_we && wr.clr) || clr_wake;
    assign idx = use_rst ? 3'(RST_IDX) : {1'b0, sel_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sel_q <= '0;
        else if (mode_we) sel_q <= wr.sel;
    end

    bt_prescaler #(
        .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3), .TAP_RST(TAP_RST)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .idx(idx), .tick(tick)
    );

    bt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(tick), .cnt(count_o), .ovf(ovf)
    );

    bt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ovf(ovf), .stop_req(stop_req), .wake(wake),
        .state_o(st), .run(run), .use_rst_tap(use_rst), .clr_wake(clr_wake),
        .in_run(in_run)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            clk_q <= 1'b0;
        end else begin
            irq_q <= ovf && in_run;
            if (ovf && in_run) clk_q <= ~clk_q;
        end
    end

    assign irq_o       = irq_q;
    assign clk_out_o   = clk_q;
    assign wait_done_o = in_run;

    AST_CLKOUT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (clk_out_o != $past(clk_out_o))); // R5
    AST_NO_IRQ_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_STOP) |-> !irq_o); // R8
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R4

endmodule

// File: tb/basic_itimer_tb_top.sv
module basic_itimer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 4;
    localparam int T0 = 5, T1 = 3, T2 = 2, T3 = 1, TR = 4;
    localparam int WDOG = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_we = 1'b0, stop_req = 1'b0, wake = 1'b0;
    logic [2:0] mode_wdata = '0;
    logic irq_o, clk_out_o, wait_done_o;
    logic [CW-1:0] count_o;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    basic_itimer #(.CNT_W(CW), .TAP0(T0), .TAP1(T1), .TAP2(T2), .TAP3(T3), .TAP_RST(TR))
    dut_i (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .stop_req(stop_req), .wake(wake), .irq_o(irq_o), .clk_out_o(clk_out_o),
        .wait_done_o(wait_done_o), .count_o(count_o)
    );

    function automatic int tap_of(int s);
        case (s)
            0: return T0;
            1: return T1;
            2: return T2;
            default: return T3;
        endcase
    endfunction

    function automatic int per(int s);
        return 1 << (tap_of(s) + CW);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic done();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            done();
        end
    end

    // clear and select: returns with write edge just passed
    task automatic write_mode(int s);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = {1'b1, 2'(s)};
        @(negedge clk);
        mode_we = 1'b0;
        mode_wdata = '0;
    endtask

    // counts negedges until irq seen; counts from current negedge
    task automatic wait_irq(output int n, input int lim);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_o && n < lim);
    endtask

    task automatic reset_wait(bit poke_stop);
        int n, irqs;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        irqs = 0;
        while (n < 4000) begin
            @(negedge clk);
            n++;
            stop_req = poke_stop && (n >= 10 && n < 20);
            if (irq_o) irqs++;
            if (wait_done_o) break;
        end
        stop_req = 1'b0;
        chk(n == (1 << (TR + CW)), "R2 reset wait length", n, 1 << (TR + CW));
        chk(irqs == 0, "R2 no irq in reset wait", irqs, 0);
    endtask

    initial begin
        int n, c0, cs, p;
        repeat (2) @(negedge clk);
        chk(count_o == 0, "R1 count in reset", int'(count_o), 0);
        chk(!wait_done_o && !irq_o && !clk_out_o, "R1 outputs low in reset",
            {wait_done_o, irq_o, clk_out_o}, 0);

        reset_wait(1'b0);

        // interval sweep
        for (int s = 0; s < 4; s++) begin
            p = per(s);
            write_mode(s);
            chk(count_o == 0, "R6 count zero after clear", int'(count_o), 0);
            c0 = clk_out_o;
            n = 0;
            do begin
                @(negedge clk);
                n++;
                if (n == (3 << tap_of(s)) + 1)
                    chk(count_o == 3, "R7 count rate", int'(count_o), 3);
            end while (!irq_o && n < 5000);
            chk(n == p, "R6 first interval after clear", n, p);
            chk(clk_out_o == !c0, "R5 clk_out toggles with irq", clk_out_o, !c0);
            @(negedge clk);
            chk(!irq_o, "R4 irq single pulse", irq_o, 0);
            wake = 1'b1;
            @(negedge clk);
            wake = 1'b0;
            wait_irq(n, 5000);
            chk(n + 2 == p, "R3 interval period (R10 wake ignored in run)", n + 2, p);
            chk(clk_out_o == c0, "R5 clk_out second toggle", clk_out_o, c0);
        end

        // stop and wake for every interval
        for (int s = 0; s < 4; s++) begin
            p = per(s);
            write_mode(s);
            repeat (p / 2 + 3) @(negedge clk);
            stop_req = 1'b1;
            @(negedge clk);
            stop_req = 1'b0;
            chk(!wait_done_o, "R8 wait_done low in stop", wait_done_o, 0);
            cs = count_o;
            c0 = clk_out_o;
            n = 0;
            for (int k = 0; k < 3 * p; k++) begin
                @(negedge clk);
                if (irq_o) n++;
            end
            chk(n == 0, "R8 no irq in stop", n, 0);
            chk(count_o == cs, "R8 count frozen", int'(count_o), cs);
            chk(clk_out_o == c0, "R8 clk_out frozen", clk_out_o, c0);
            wake = 1'b1;
            @(negedge clk);
            wake = 1'b0;
            chk(count_o == 0, "R9 wake clears count", int'(count_o), 0);
            n = 1;
            cs = 0;
            while (!wait_done_o && n < 5000) begin
                @(negedge clk);
                n++;
                if (irq_o) cs++;
            end
            chk(n == p + 1, "R9 wake wait length", n, p + 1);
            chk(cs == 0, "R9 no irq in wake wait", cs, 0);
            wait_irq(n, 5000);
            chk(n == p, "R9 first irq after wake wait", n, p);
        end

        // stop request ignored during reset wait
        reset_wait(1'b1);
        n = 0;
        repeat (50) begin
            @(negedge clk);
            if (!wait_done_o) n++;
        end
        chk(n == 0, "R10 stop_req ignored in reset wait", n, 0);

        done();
    end
endmodule